// File: doc/BRIEF.md
# Infrared Link Controller Host Register Bank

This block is the byte-wide register bank that a host processor uses to steer an infrared link controller. The host reaches it through a write strobe and a read strobe, a 5-bit offset and an 8-bit data path. Through it the host sets the receive and transmit slot indices, the base address of the descriptor ring and the ring sizes for each direction. It can also nudge the ring engine to look at its descriptors again, and it can switch the controller off through a configuration register.

The datapath reports five kinds of event as single-cycle pulses. These are transmit done, receive done, transmit underflow, receive overflow and serial gap received. Each event latches a status bit. The host clears a status bit by writing a one to it, and the bank raises its interrupt line whenever a latched bit is also enabled.

The bank gives the datapath four things: the ring base assembled into a 32-bit address with its low ten bits at zero, the two ring sizes decoded into slot counts, a one-cycle prompt pulse, and a controller-off level.

Top module: `irlink_regbank`

## Requirements
- R1: After reset every stored field is zero. Reading the status register at offset 0x0C or the enable register at offset 0x0D returns 0x07. The interrupt, prompt, off and read-data outputs are all low.
- R2: Offset 0x00 holds the receive slot index and offset 0x01 holds the transmit slot index. Each keeps only data bits 5..0, drives its own output and reads back with bits 7..6 at zero.
- R3: The ring base output is built from three registers, and its bits 9..0 are always zero:
  - offset 0x04 supplies address bits 17..10;
  - offset 0x05 supplies address bits 25..18;
  - bits 5..0 of offset 0x02 supply address bits 31..26, and offset 0x02 reads back with bits 7..6 at zero.
- R4: Offset 0x07 holds the ring size register, which reads back as written:
  - bits 3..0 set the receive ring size and bits 7..4 set the transmit ring size;
  - the codes 0x0, 0x1, 0x3, 0x7 and 0xF decode to 4, 8, 16, 32 and 64 slots;
  - any other code decodes to 4 slots.
- R5: A write to offset 0x09 with data bit 0 set makes the prompt output high for exactly the next cycle. A write there with bit 0 clear produces no pulse. Offset 0x09 reads as zero.
- R6: Each event input sets one status bit and holds it until it is cleared. Event bit 4 (transmit done) sets status bit 7, event bit 3 (receive done) sets bit 6, event bit 2 (transmit underflow) sets bit 5, event bit 1 (receive overflow) sets bit 4, and event bit 0 (serial gap) sets bit 3. Status bits 2..0 read as ones.
- R7: Writing to offset 0x0C clears each status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R8: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: A write to offset 0x0D stores data bits 7..3 as the enable mask, using the same layout as the status register. The register reads back with bits 2..0 at one.
- R10: The interrupt output is high exactly when some status bit and its matching enable bit are both set.
- R11: Offset 0x0E stores data bits 4..0 and reads back with bits 7..5 at zero. The controller-off output is high when bit 0 or bit 1 of this register is set.
- R12: Offsets that are not mapped read as zero. Writes to them change no register and no output.
- R13: A read strobe loads the read-data output on the next clock with the value of the addressed register as it stood before that edge. Without a read strobe, the read-data output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Byte write strobe |
| host_rd | input | 1 | Byte read strobe |
| host_addr | input | 5 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| evt | input | 5 | Event pulses: bit 4 transmit done, bit 3 receive done, bit 2 transmit underflow, bit 1 receive overflow, bit 0 serial gap |
| irq | output | 1 | Interrupt request |
| rx_slot | output | 6 | Receive slot index |
| tx_slot | output | 6 | Transmit slot index |
| ring_base | output | 32 | Descriptor ring base address |
| rx_ring_slots | output | 7 | Decoded receive ring slot count |
| tx_ring_slots | output | 7 | Decoded transmit ring slot count |
| prompt | output | 1 | One-cycle request to re-examine the ring |
| ctrl_off | output | 1 | Controller switched off |

## Verification
The assertions assume that every input holds a known value on each clock edge once reset is released. They also assume that an event bit may stay high for several cycles and that each high cycle counts as a fresh pulse. The stimulus drives every input on the falling edge and always with defined values. It mixes any combination of events with writes to every offset, both mapped and unmapped, and with arbitrary data, so collisions between events and clearing writes occur naturally. Directed sequences cover all sixteen ring-size codes, the collision between an event and a clear, prompt writes with bit 0 clear, and writes to unmapped offsets.

// File: rtl/irlink_pkg.sv
package irlink_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int NUM_SRC    = 5;
  localparam int LOW_W      = DATA_W - NUM_SRC;
  localparam int SLOT_W     = 6;
  localparam int CNT_W      = SLOT_W + 1;
  localparam int BASE_SHIFT = 10;
  localparam int HI_W       = 32 - BASE_SHIFT - 2 * DATA_W;
  localparam int CFG_W      = 5;

  localparam logic [ADDR_W-1:0] OFS_RXSLOT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TXSLOT  = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_BASE_HI = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_BASE_LO = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_BASE_MD = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_RSIZE   = 5'h07;
  localparam logic [ADDR_W-1:0] OFS_PROMPT  = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_ISTAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 5'h0E;
endpackage

// File: rtl/irlink_size_dec.sv
module irlink_size_dec #(
  parameter int CNT_W = 7
) (
  input  logic [3:0]       code,
  output logic [CNT_W-1:0] slots
);
  logic [2:0] shift;

  always_comb begin
    case (code)
      4'h1:    shift = 3'd3;
      4'h3:    shift = 3'd4;
      4'h7:    shift = 3'd5;
      4'hF:    shift = 3'd6;
      default: shift = 3'd2;
    endcase
    slots = CNT_W'(1) << shift;
  end

  // R4: the decoded slot count is always a single power of two, at least 4
  always_comb begin
    p_size_onehot_r4: assert ($onehot(slots) && (slots >= CNT_W'(4)));
  end
endmodule

// File: rtl/irlink_ring_cfg.sv
module irlink_ring_cfg
  import irlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [HI_W-1:0]   base_hi,
  output logic [DATA_W-1:0] base_md,
  output logic [DATA_W-1:0] base_lo,
  output logic [DATA_W-1:0] rsize,
  output logic [31:0]       ring_base,
  output logic [CNT_W-1:0]  rx_slots,
  output logic [CNT_W-1:0]  tx_slots
);
  logic rx_en, tx_en, hi_en, md_en, lo_en, rs_en;
  logic [SLOT_W-1:0] rx_d, tx_d;
  logic [HI_W-1:0]   hi_d;
  logic [DATA_W-1:0] md_d, lo_d, rs_d;
  logic [1:0][CNT_W-1:0] dec_slots;

  always_comb begin
    rx_en = wr && (addr == OFS_RXSLOT);
    tx_en = wr && (addr == OFS_TXSLOT);
    hi_en = wr && (addr == OFS_BASE_HI);
    md_en = wr && (addr == OFS_BASE_MD);
    lo_en = wr && (addr == OFS_BASE_LO);
    rs_en = wr && (addr == OFS_RSIZE);
    rx_d  = wdata[SLOT_W-1:0];
    tx_d  = wdata[SLOT_W-1:0];
    hi_d  = wdata[HI_W-1:0];
    md_d  = wdata;
    lo_d  = wdata;
    rs_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_slot <= '0;
      tx_slot <= '0;
      base_hi <= '0;
      base_md <= '0;
      base_lo <= '0;
      rsize   <= '0;
    end else begin
      if (rx_en) rx_slot <= rx_d;
      if (tx_en) tx_slot <= tx_d;
      if (hi_en) base_hi <= hi_d;
      if (md_en) base_md <= md_d;
      if (lo_en) base_lo <= lo_d;
      if (rs_en) rsize   <= rs_d;
    end
  end

  assign ring_base = {base_hi, base_md, base_lo, {BASE_SHIFT{1'b0}}};

  for (genvar g = 0; g < 2; g++) begin : g_dec
    irlink_size_dec #(.CNT_W(CNT_W)) u_dec (
      .code  (rsize[4*g +: 4]),
      .slots (dec_slots[g])
    );
  end

  assign rx_slots = dec_slots[0];
  assign tx_slots = dec_slots[1];

  // R2: slot indices change only through their own offsets
  p_rxslot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_RXSLOT) |=> $stable(rx_slot));
  p_txslot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_TXSLOT) |=> $stable(tx_slot));
  // R3: the assembled base changes only after a write to one of its three bytes
  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (addr == OFS_BASE_HI || addr == OFS_BASE_MD || addr == OFS_BASE_LO))
      |=> $stable(ring_base));
endmodule

// File: rtl/irlink_irq_ctrl.sv
module irlink_irq_ctrl #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sts_wr,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] wsrc,
  input  logic [NUM_SRC-1:0] evt,
  output logic [NUM_SRC-1:0] sts,
  output logic [NUM_SRC-1:0] en,
  output logic               irq
);
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] sts_d;
  logic               sts_ce;

  always_comb begin
    clr_mask = sts_wr ? wsrc : '0;
    sts_d    = (sts & ~clr_mask) | evt;
    sts_ce   = sts_wr || (evt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      if (sts_ce) sts <= sts_d;
      if (en_wr)  en  <= wsrc;
    end
  end

  assign irq = |(sts & en);

  // R6: an event pulse leaves its status bit set
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));
  // R7: a clearing write removes the bits it names unless an event arrives
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((sts & $past(wsrc & ~evt)) == '0));
  // R7: no write and no event leaves status untouched
  p_sts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr && evt == '0) |=> $stable(sts));
  // R8: an event beats a simultaneous clear
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && (evt & wsrc) != '0) |=> ((sts & $past(evt & wsrc)) == $past(evt & wsrc)));
  // R9: the enable mask changes only on its own write
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en));
endmodule

// File: rtl/irlink_regbank.sv
module irlink_regbank
  import irlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [4:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [4:0]        evt,
  output logic              irq,
  output logic [5:0]        rx_slot,
  output logic [5:0]        tx_slot,
  output logic [31:0]       ring_base,
  output logic [6:0]        rx_ring_slots,
  output logic [6:0]        tx_ring_slots,
  output logic              prompt,
  output logic              ctrl_off
);
  logic [HI_W-1:0]    base_hi;
  logic [DATA_W-1:0]  base_md, base_lo, rsize;
  logic [NUM_SRC-1:0] sts, en;
  logic               sts_wr, en_wr;

  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic               cfg_en;
  logic               prompt_d;
  logic [DATA_W-1:0]  rd_mux, rdata_d;

  irlink_ring_cfg u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (host_wr),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .rx_slot   (rx_slot),
    .tx_slot   (tx_slot),
    .base_hi   (base_hi),
    .base_md   (base_md),
    .base_lo   (base_lo),
    .rsize     (rsize),
    .ring_base (ring_base),
    .rx_slots  (rx_ring_slots),
    .tx_slots  (tx_ring_slots)
  );

  assign sts_wr = host_wr && (host_addr == OFS_ISTAT);
  assign en_wr  = host_wr && (host_addr == OFS_IEN);

  irlink_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .sts_wr (sts_wr),
    .en_wr  (en_wr),
    .wsrc   (host_wdata[DATA_W-1:LOW_W]),
    .evt    (evt),
    .sts    (sts),
    .en     (en),
    .irq    (irq)
  );

  always_comb begin
    cfg_en   = host_wr && (host_addr == OFS_CFG);
    cfg_d    = host_wdata[CFG_W-1:0];
    prompt_d = host_wr && (host_addr == OFS_PROMPT) && host_wdata[0];
    case (host_addr)
      OFS_RXSLOT:  rd_mux = DATA_W'(rx_slot);
      OFS_TXSLOT:  rd_mux = DATA_W'(tx_slot);
      OFS_BASE_HI: rd_mux = DATA_W'(base_hi);
      OFS_BASE_LO: rd_mux = base_lo;
      OFS_BASE_MD: rd_mux = base_md;
      OFS_RSIZE:   rd_mux = rsize;
      OFS_ISTAT:   rd_mux = {sts, {LOW_W{1'b1}}};
      OFS_IEN:     rd_mux = {en, {LOW_W{1'b1}}};
      OFS_CFG:     rd_mux = DATA_W'(cfg_q);
      default:     rd_mux = '0;
    endcase
    rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      prompt     <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (cfg_en)  cfg_q      <= cfg_d;
      if (host_rd) host_rdata <= rdata_d;
      prompt <= prompt_d;
    end
  end

  assign ctrl_off = cfg_q[0] | cfg_q[1];

  // R5: a prompt pulse is always caused by a prompt write one cycle earlier
  p_prompt_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prompt |-> $past(host_wr && host_addr == OFS_PROMPT && host_wdata[0]));
  // R5: a pulse lasts one cycle unless another prompt write follows
  p_prompt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prompt && !(host_wr && host_addr == OFS_PROMPT && host_wdata[0])) |=> !prompt);
  // R11: configuration changes only on its own write
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(ctrl_off));
  // R13: read data holds without a read strobe
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
  // R10: the interrupt needs at least one enabled source
  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != '0) && (sts != '0));
endmodule

// File: tb/irlink_regbank_tb.sv
module irlink_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd;
  logic [4:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [4:0] evt;
  logic       irq, prompt, ctrl_off;
  logic [5:0] rx_slot, tx_slot;
  logic [31:0] ring_base;
  logic [6:0] rx_ring_slots, tx_ring_slots;

  int total = 0;
  int bad   = 0;

  // bench model of the register contents
  logic [5:0] m_rx, m_tx, m_hi;
  logic [7:0] m_lo, m_md, m_rs, m_rdata;
  logic [4:0] m_sts, m_en, m_cfg;
  logic       m_prompt;

  always #(CLK_PERIOD/2) clk = ~clk;

  irlink_regbank u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .evt           (evt),
    .irq           (irq),
    .rx_slot       (rx_slot),
    .tx_slot       (tx_slot),
    .ring_base     (ring_base),
    .rx_ring_slots (rx_ring_slots),
    .tx_ring_slots (tx_ring_slots),
    .prompt        (prompt),
    .ctrl_off      (ctrl_off)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] dec_size(input logic [3:0] c);
    case (c)
      4'h0: return 7'd4;
      4'h1: return 7'd8;
      4'h3: return 7'd16;
      4'h7: return 7'd32;
      4'hF: return 7'd64;
      default: return 7'd4;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00: return {2'b00, m_rx};
      5'h01: return {2'b00, m_tx};
      5'h02: return {2'b00, m_hi};
      5'h04: return m_lo;
      5'h05: return m_md;
      5'h07: return m_rs;
      5'h0C: return {m_sts, 3'b111};
      5'h0D: return {m_en, 3'b111};
      5'h0E: return {3'b000, m_cfg};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00, 5'h01: return "R2";
      5'h02, 5'h04, 5'h05: return "R3";
      5'h07: return "R4";
      5'h09: return "R5";
      5'h0C: return "R6";
      5'h0D: return "R9";
      5'h0E: return "R11";
      default: return "R12";
    endcase
  endfunction

  // one bus cycle: drive on the falling edge, model at the rising edge, check on the next falling edge
  task automatic step(input bit wr, input logic [4:0] a, input logic [7:0] d, input bit rd, input logic [4:0] e);
    host_wr = wr; host_addr = a; host_wdata = d; host_rd = rd; evt = e;
    @(posedge clk);
    if (rd) m_rdata = exp_read(a);
    m_prompt = wr && (a == 5'h09) && d[0];
    if (wr) begin
      case (a)
        5'h00: m_rx = d[5:0];
        5'h01: m_tx = d[5:0];
        5'h02: m_hi = d[5:0];
        5'h04: m_lo = d;
        5'h05: m_md = d;
        5'h07: m_rs = d;
        5'h0D: m_en = d[7:3];
        5'h0E: m_cfg = d[4:0];
        default: ;
      endcase
    end
    m_sts = (m_sts & ~((wr && a == 5'h0C) ? d[7:3] : 5'h00)) | e;
    @(negedge clk);
    chk(host_rdata == m_rdata, $sformatf("R13 %s rdata addr=%0h", tag_of(a), a), host_rdata, m_rdata);
    chk(rx_slot == m_rx && tx_slot == m_tx, "R2 slot outputs", {rx_slot, tx_slot}, {m_rx, m_tx});
    chk(ring_base == {m_hi, m_md, m_lo, 10'b0}, "R3 ring base", ring_base, {m_hi, m_md, m_lo, 10'b0});
    chk(rx_ring_slots == dec_size(m_rs[3:0]), "R4 rx size", rx_ring_slots, dec_size(m_rs[3:0]));
    chk(tx_ring_slots == dec_size(m_rs[7:4]), "R4 tx size", tx_ring_slots, dec_size(m_rs[7:4]));
    chk(prompt == m_prompt, "R5 prompt", prompt, m_prompt);
    chk(irq == |(m_sts & m_en), "R10 irq", irq, |(m_sts & m_en));
    chk(ctrl_off == (m_cfg[0] | m_cfg[1]), "R11 ctrl_off", ctrl_off, m_cfg[0] | m_cfg[1]);
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [7:0] exp, input string tag);
    step(1'b0, a, 8'h00, 1'b1, 5'h00);
    chk(host_rdata == exp, tag, host_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] maplist [10];
    maplist = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h05, 5'h07, 5'h09, 5'h0C, 5'h0D, 5'h0E};
    void'($urandom(32'd20240611));
    m_rx = '0; m_tx = '0; m_hi = '0; m_lo = '0; m_md = '0; m_rs = '0; m_rdata = '0;
    m_sts = '0; m_en = '0; m_cfg = '0; m_prompt = 1'b0;
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values
    chk(irq == 0 && prompt == 0 && ctrl_off == 0, "R1 reset outputs", {irq, prompt, ctrl_off}, 0);
    chk(ring_base == 0 && host_rdata == 0, "R1 reset base/rdata", ring_base, 0);
    chk(rx_ring_slots == 7'd4, "R1 reset rx size", rx_ring_slots, 4);
    rst_n = 1'b1;
    @(negedge clk);
    rd_expect(5'h0C, 8'h07, "R1 status reset read");
    rd_expect(5'h0D, 8'h07, "R1 enable reset read");
    rd_expect(5'h00, 8'h00, "R1 rx slot reset read");

    // R2: masking of slot indices
    step(1'b1, 5'h00, 8'hFF, 1'b0, 5'h00);
    rd_expect(5'h00, 8'h3F, "R2 rx slot masked");
    step(1'b1, 5'h01, 8'hC5, 1'b0, 5'h00);
    rd_expect(5'h01, 8'h05, "R2 tx slot masked");

    // R3: base packing, high byte upper bits
    step(1'b1, 5'h02, 8'hFF, 1'b0, 5'h00);
    step(1'b1, 5'h04, 8'hA5, 1'b0, 5'h00);
    step(1'b1, 5'h05, 8'h3C, 1'b0, 5'h00);
    chk(ring_base == 32'hFC_F2_94_00, "R3 packed base", ring_base, 32'hFCF29400);
    rd_expect(5'h02, 8'h3F, "R3 high byte reads masked");

    // R4: every nibble code in both halves
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 5'h07, {c[3:0], c[3:0]}, 1'b0, 5'h00);
      chk(tx_ring_slots == dec_size(c[3:0]), "R4 directed code", tx_ring_slots, dec_size(c[3:0]));
    end

    // R5: prompt only with bit0
    step(1'b1, 5'h09, 8'hFE, 1'b0, 5'h00);
    chk(prompt == 1'b0, "R5 no pulse with bit0 clear", prompt, 0);
    step(1'b1, 5'h09, 8'h01, 1'b0, 5'h00);
    chk(prompt == 1'b1, "R5 pulse", prompt, 1);
    step(1'b0, 5'h00, 8'h00, 1'b0, 5'h00);
    chk(prompt == 1'b0, "R5 pulse ends", prompt, 0);
    rd_expect(5'h09, 8'h00, "R5 prompt reads zero");

    // R6 / R7 / R8 / R10
    step(1'b0, 5'h00, 8'h00, 1'b0, 5'h1F);
    rd_expect(5'h0C, 8'hFF, "R6 all events latched");
    step(1'b1, 5'h0C, 8'h48, 1'b0, 5'h00);
    rd_expect(5'h0C, 8'hB7, "R7 partial clear");
    step(1'b1, 5'h0C, 8'hF8, 1'b0, 5'h10);
    rd_expect(5'h0C, 8'h87, "R8 event wins over clear");
    step(1'b1, 5'h0D, 8'h47, 1'b0, 5'h00);
    chk(irq == 1'b0, "R10 disabled source", irq, 0);
    rd_expect(5'h0D, 8'h47, "R9 enable readback");
    step(1'b1, 5'h0D, 8'h80, 1'b0, 5'h00);
    chk(irq == 1'b1, "R10 enabled source", irq, 1);
    step(1'b1, 5'h0C, 8'h80, 1'b0, 5'h00);
    chk(irq == 1'b0, "R10 cleared", irq, 0);

    // R11: config
    step(1'b1, 5'h0E, 8'hFE, 1'b0, 5'h00);
    chk(ctrl_off == 1'b1, "R11 disable bit", ctrl_off, 1);
    rd_expect(5'h0E, 8'h1E, "R11 upper bits zero");
    step(1'b1, 5'h0E, 8'h08, 1'b0, 5'h00);
    chk(ctrl_off == 1'b0, "R11 on", ctrl_off, 0);

    // R12: unmapped offsets
    step(1'b1, 5'h03, 8'hFF, 1'b0, 5'h00);
    step(1'b1, 5'h1F, 8'hFF, 1'b0, 5'h00);
    chk(ring_base == 32'hFCF29400, "R12 base unaffected", ring_base, 32'hFCF29400);
    rd_expect(5'h03, 8'h00, "R12 unmapped reads zero");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [4:0] e;
      if (($urandom % 4) != 0) a = maplist[$urandom % 10];
      else a = 5'($urandom);
      e = ($urandom % 3 == 0) ? 5'($urandom) : 5'h00;
      step(($urandom % 2) == 1, a, 8'($urandom), ($urandom % 2) == 1, e);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule